// File: doc/BRIEF.md
# Per-Pin Source Multiplexer for Daughterboard GPIO with Transmit/Receive Automation

This block drives a bank of general-purpose pins that is split into two groups: a transmit-side group in the low pin positions and a receive-side group above it. Each pin has a direction bit. For every pin configured as an output, a 2-bit select field picks one of four sources: a data word written by software, an automatic value taken from a transmit/receive state table, or one of two debug buses from the surrounding logic.

The automatic source follows the radio's activity. Two status inputs, `tx_active` and `rx_active`, decode with no register in between into one of four named states: `ATR_IDLE` (neither active), `ATR_TX_ONLY`, `ATR_RX_ONLY` and `ATR_FULL` (both active). The state moves to another state at once whenever either status input changes, so any change in activity is a transition. Each state owns one programmable table entry. The low part of the entry feeds the transmit-side pins and the high part feeds the receive-side pins. Software configures the block through a single-cycle write bus. The actual levels on all pins are always visible on a readback port.

Top module: `gpio_atr_mux`

## Requirements
- R1: After reset every register reads as zero, so all pins are inputs (`pad_oe` = 0) and `pad_out` = 0.
- R2: An output pin whose select code is 0 drives the bit of the data register (address 0) at its own position.
- R3: An output pin whose select code is 1 drives its bit of the table entry for the current activity state.
- R4: Select code 2 drives the pin from `dbg0`, and select code 3 drives it from `dbg1`, each at the pin's own bit position.
- R5: The direction register (address 1) sets `pad_oe` per pin. A pin whose direction bit is 0 has `pad_oe` low and `pad_out` low, whatever its select code.
- R6: The state is {`tx_active`,`rx_active`}: 00 is idle, 01 is receive-only, 10 is transmit-only and 11 is full duplex. The entry for state code s is at address 4+s, and a change of activity reaches the pins in the same cycle.
- R7: Transmit-side pins 0..TX_W-1 take their select codes from address 2 (pin i at bits 2i+1:2i) and the low TX_W bits of the table entry. Receive-side pins take their select codes from address 3 (receive pin j at bits 2j+1:2j) and the entry bits above TX_W.
- R8: `rd_pins` equals `pad_in` on every pin at all times, whatever the direction bits are set to.
- R9: A write reaches the outputs in the cycle after the clock edge that samples it. Writes to addresses 8..15 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 4 | Register address |
| wr_data | input | DATA_W | Write data |
| tx_active | input | 1 | Transmit activity status |
| rx_active | input | 1 | Receive activity status |
| dbg0 | input | TX_W+RX_W | Debug bus 0 |
| dbg1 | input | TX_W+RX_W | Debug bus 1 |
| pad_in | input | TX_W+RX_W | Levels observed on the pins |
| pad_out | output | TX_W+RX_W | Value driven onto output pins |
| pad_oe | output | TX_W+RX_W | Per-pin output enable; low means tri-stated |
| rd_pins | output | TX_W+RX_W | Readback of the pin levels |

## Verification
The source selection is tried with every pin on a single source, with each group on a different debug bus, and with a mixed pattern that gives adjacent pins different codes. The mixed pattern exposes swapped or misaligned select fields that uniform settings would hide. The activity decode is tried in all four states, using table entries that differ in every bit group, so that a swapped pair of states or swapped halves of an entry shows up. Further patterns cover partial direction masks with all-ones data, readback of an arbitrary pin pattern with the pins set as inputs, and a write to an unmapped address.

// File: rtl/gpio_atr_pkg.sv
package gpio_atr_pkg;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_DATA  = 4'd0;
    localparam logic [ADDR_W-1:0] A_DIR   = 4'd1;
    localparam logic [ADDR_W-1:0] A_TXSEL = 4'd2;
    localparam logic [ADDR_W-1:0] A_RXSEL = 4'd3;

    // state code is {tx_active, rx_active}; table entry lives at 4 + code
    typedef enum logic [1:0] {
        ATR_IDLE    = 2'b00,
        ATR_RX_ONLY = 2'b01,
        ATR_TX_ONLY = 2'b10,
        ATR_FULL    = 2'b11
    } atr_state_e;

    typedef enum logic [1:0] {
        SRC_REG  = 2'd0,
        SRC_ATR  = 2'd1,
        SRC_DBG0 = 2'd2,
        SRC_DBG1 = 2'd3
    } pin_src_e;

endpackage

// File: rtl/gpio_atr_regs.sv
module gpio_atr_regs
    import gpio_atr_pkg::*;
#(
    parameter int TX_W   = 16,
    parameter int RX_W   = 16,
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [TX_W+RX_W-1:0]       data_q,
    output logic [TX_W+RX_W-1:0]       dir_q,
    output logic [2*TX_W-1:0]          tx_sel_q,
    output logic [2*RX_W-1:0]          rx_sel_q,
    output logic [3:0][TX_W+RX_W-1:0]  atr_q
);
    localparam int N = TX_W + RX_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q   <= '0;
            dir_q    <= '0;
            tx_sel_q <= '0;
            rx_sel_q <= '0;
            atr_q    <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_DATA:  data_q   <= wr_data[N-1:0];
                A_DIR:   dir_q    <= wr_data[N-1:0];
                A_TXSEL: tx_sel_q <= wr_data[2*TX_W-1:0];
                A_RXSEL: rx_sel_q <= wr_data[2*RX_W-1:0];
                4'd4, 4'd5, 4'd6, 4'd7:
                         atr_q[wr_addr[1:0]] <= wr_data[N-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_atr_decode.sv
module gpio_atr_decode
    import gpio_atr_pkg::*;
#(
    parameter int N = 32
) (
    input  logic                tx_active,
    input  logic                rx_active,
    input  logic [3:0][N-1:0]   atr_q,
    output logic [N-1:0]        atr_word
);
    atr_state_e state;

    always_comb begin
        state = atr_state_e'({tx_active, rx_active});
    end

    always_comb begin
        unique case (state)
            ATR_IDLE:    atr_word = atr_q[0];
            ATR_RX_ONLY: atr_word = atr_q[1];
            ATR_TX_ONLY: atr_word = atr_q[2];
            ATR_FULL:    atr_word = atr_q[3];
        endcase
    end

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_atr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [2*W-1:0] sel,
    input  logic [W-1:0]   reg_bits,
    input  logic [W-1:0]   atr_bits,
    input  logic [W-1:0]   dbg0_bits,
    input  logic [W-1:0]   dbg1_bits,
    input  logic [W-1:0]   dir_bits,
    output logic [W-1:0]   pin_out,
    output logic [W-1:0]   pin_oe
);
    for (genvar g = 0; g < W; g++) begin : g_pin
        logic src_bit;

        always_comb begin
            unique case (pin_src_e'(sel[2*g +: 2]))
                SRC_REG:  src_bit = reg_bits[g];
                SRC_ATR:  src_bit = atr_bits[g];
                SRC_DBG0: src_bit = dbg0_bits[g];
                SRC_DBG1: src_bit = dbg1_bits[g];
            endcase
        end

        assign pin_out[g] = dir_bits[g] & src_bit;
        assign pin_oe[g]  = dir_bits[g];
    end

endmodule

// File: rtl/gpio_atr_mux.sv
module gpio_atr_mux
    import gpio_atr_pkg::*;
#(
    parameter int TX_W   = 16,
    parameter int RX_W   = 16,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [3:0]             wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   tx_active,
    input  logic                   rx_active,
    input  logic [TX_W+RX_W-1:0]   dbg0,
    input  logic [TX_W+RX_W-1:0]   dbg1,
    input  logic [TX_W+RX_W-1:0]   pad_in,
    output logic [TX_W+RX_W-1:0]   pad_out,
    output logic [TX_W+RX_W-1:0]   pad_oe,
    output logic [TX_W+RX_W-1:0]   rd_pins
);
    localparam int N = TX_W + RX_W;

    logic [N-1:0]        data_q;
    logic [N-1:0]        dir_q;
    logic [2*TX_W-1:0]   tx_sel_q;
    logic [2*RX_W-1:0]   rx_sel_q;
    logic [3:0][N-1:0]   atr_q;
    logic [N-1:0]        atr_word;

    gpio_atr_regs #(.TX_W(TX_W), .RX_W(RX_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .data_q   (data_q),
        .dir_q    (dir_q),
        .tx_sel_q (tx_sel_q),
        .rx_sel_q (rx_sel_q),
        .atr_q    (atr_q)
    );

    gpio_atr_decode #(.N(N)) u_decode (
        .tx_active (tx_active),
        .rx_active (rx_active),
        .atr_q     (atr_q),
        .atr_word  (atr_word)
    );

    gpio_pin_mux #(.W(TX_W)) u_tx_mux (
        .sel       (tx_sel_q),
        .reg_bits  (data_q[TX_W-1:0]),
        .atr_bits  (atr_word[TX_W-1:0]),
        .dbg0_bits (dbg0[TX_W-1:0]),
        .dbg1_bits (dbg1[TX_W-1:0]),
        .dir_bits  (dir_q[TX_W-1:0]),
        .pin_out   (pad_out[TX_W-1:0]),
        .pin_oe    (pad_oe[TX_W-1:0])
    );

    gpio_pin_mux #(.W(RX_W)) u_rx_mux (
        .sel       (rx_sel_q),
        .reg_bits  (data_q[N-1:TX_W]),
        .atr_bits  (atr_word[N-1:TX_W]),
        .dbg0_bits (dbg0[N-1:TX_W]),
        .dbg1_bits (dbg1[N-1:TX_W]),
        .dir_bits  (dir_q[N-1:TX_W]),
        .pin_out   (pad_out[N-1:TX_W]),
        .pin_oe    (pad_oe[N-1:TX_W])
    );

    assign rd_pins = pad_in;

endmodule

// File: rtl/gpio_atr_mux_chk.sv
module gpio_atr_mux_chk
    import gpio_atr_pkg::*;
#(
    parameter int N      = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [3:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              tx_active,
    input logic              rx_active,
    input logic [N-1:0]      dbg0,
    input logic [N-1:0]      dbg1,
    input logic [N-1:0]      pad_in,
    input logic [N-1:0]      pad_out,
    input logic [N-1:0]      pad_oe,
    input logic [N-1:0]      rd_pins
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe == '0 && pad_out == '0));

    assert_input_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (pad_out & ~pad_oe) == '0);

    assert_dir_write_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_DIR) |=> (pad_oe == $past(wr_data[N-1:0])));

    assert_hold_without_cause_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(!wr_en) && $stable(tx_active) && $stable(rx_active)
         && $stable(dbg0) && $stable(dbg1)) |-> ($stable(pad_out) && $stable(pad_oe)));

    assert_readback_R8: assert property (@(posedge clk) disable iff (rst)
        rd_pins == pad_in);

endmodule

bind gpio_atr_mux gpio_atr_mux_chk #(.N(TX_W + RX_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .tx_active (tx_active),
    .rx_active (rx_active),
    .dbg0      (dbg0),
    .dbg1      (dbg1),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .rd_pins   (rd_pins)
);

// File: tb/test_gpio_atr_mux.sv
module test_gpio_atr_mux;

    localparam int TX_W = 16;
    localparam int RX_W = 16;
    localparam int N    = TX_W + RX_W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          tx_active = 1'b0;
    logic          rx_active = 1'b0;
    logic [N-1:0]  dbg0 = '0;
    logic [N-1:0]  dbg1 = '0;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_out;
    logic [N-1:0]  pad_oe;
    logic [N-1:0]  rd_pins;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    gpio_atr_mux #(.TX_W(TX_W), .RX_W(RX_W), .DATA_W(32)) i_gpio_atr_mux (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tx_active(tx_active), .rx_active(rx_active), .dbg0(dbg0), .dbg1(dbg1),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .rd_pins(rd_pins)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive on the falling edge, sampled at the next rising edge, settled by the next falling edge
    task automatic write_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic set_activity(input logic tx, input logic rx);
        @(negedge clk);
        tx_active = tx; rx_active = rx;
        #1;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 pad_oe", pad_oe, '0);
        check("R1 pad_out", pad_out, '0);
    endtask

    task automatic t_readback;
        @(negedge clk);
        pad_in = 32'h3CA5_0F96;
        #1;
        check("R8 readback inputs", rd_pins, 32'h3CA5_0F96);
        write_reg(4'd1, 32'hFFFF_0000);
        pad_in = 32'h0000_FFFF;
        #1;
        check("R8 readback mixed dir", rd_pins, 32'h0000_FFFF);
        write_reg(4'd1, 32'h0);
    endtask

    task automatic t_data_src;
        write_reg(4'd2, 32'h0);
        write_reg(4'd3, 32'h0);
        write_reg(4'd0, 32'hA5C3_5A3C);
        write_reg(4'd1, 32'hFFFF_FFFF);
        check("R2 data source", pad_out, 32'hA5C3_5A3C);
        check("R9 dir write oe", pad_oe, 32'hFFFF_FFFF);
    endtask

    task automatic t_debug;
        @(negedge clk);
        dbg0 = 32'h1234_5678; dbg1 = 32'h9ABC_DEF0;
        write_reg(4'd2, 32'hAAAA_AAAA);
        write_reg(4'd3, 32'hFFFF_FFFF);
        check("R4 R7 tx dbg0 rx dbg1", pad_out, 32'h9ABC_5678);
        write_reg(4'd2, 32'hFFFF_FFFF);
        write_reg(4'd3, 32'hAAAA_AAAA);
        check("R4 R7 tx dbg1 rx dbg0", pad_out, 32'h1234_DEF0);
    endtask

    task automatic t_atr;
        logic [31:0] ent [4];
        ent[0] = 32'h0F0F_1111;
        ent[1] = 32'h00FF_2222;
        ent[2] = 32'h3C3C_4444;
        ent[3] = 32'hF000_8888;
        for (int s = 0; s < 4; s++) write_reg(4'(4 + s), ent[s]);
        write_reg(4'd2, 32'h5555_5555);
        write_reg(4'd3, 32'h5555_5555);
        for (int s = 0; s < 4; s++) begin
            set_activity(s[1], s[0]);
            check($sformatf("R3 R6 atr state %0d", s), pad_out, ent[s]);
        end
        set_activity(1'b0, 1'b0);
    endtask

    task automatic t_mixed;
        logic [31:0] d, a, txs, rxs;
        logic [N-1:0] exp;
        d = 32'hC3C3_9696; a = 32'h0F0F_1111;
        txs = 32'hE4E4_E4E4; rxs = 32'h1B1B_1B1B;
        write_reg(4'd0, d);
        write_reg(4'd2, txs);
        write_reg(4'd3, rxs);
        for (int p = 0; p < N; p++) begin
            logic [1:0] c;
            c = (p < TX_W) ? txs[2*p +: 2] : rxs[2*(p-TX_W) +: 2];
            case (c)
                2'd0: exp[p] = d[p];
                2'd1: exp[p] = a[p];
                2'd2: exp[p] = dbg0[p];
                default: exp[p] = dbg1[p];
            endcase
        end
        check("R7 mixed per-pin select", pad_out, exp);
    endtask

    task automatic t_dir;
        write_reg(4'd2, 32'h0);
        write_reg(4'd3, 32'hFFFF_FFFF);
        write_reg(4'd0, 32'hFFFF_FFFF);
        @(negedge clk);
        dbg1 = 32'hFFFF_FFFF;
        write_reg(4'd1, 32'h0000_F0F0);
        check("R5 partial dir out", pad_out, 32'h0000_F0F0);
        check("R5 partial dir oe", pad_oe, 32'h0000_F0F0);
        write_reg(4'd1, 32'hFFFF_0000);
        check("R5 rx-only dir out", pad_out, 32'hFFFF_0000);
    endtask

    task automatic t_unmapped;
        write_reg(4'd1, 32'hFFFF_FFFF);
        write_reg(4'd0, 32'h0000_0000);
        write_reg(4'd2, 32'h0);
        write_reg(4'd3, 32'h0);
        for (int a = 8; a < 16; a++) write_reg(4'(a), 32'hFFFF_FFFF);
        check("R9 unmapped out", pad_out, 32'h0);
        check("R9 unmapped oe", pad_oe, 32'hFFFF_FFFF);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd0; wr_data = 32'h5A5A_5A5A;
        #1;
        check("R9 before edge", pad_out, 32'h0);
        @(negedge clk);
        wr_en = 1'b0;
        check("R9 after edge", pad_out, 32'h5A5A_5A5A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_readback();
        t_data_src();
        t_debug();
        t_atr();
        t_mixed();
        t_dir();
        t_unmapped();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule